// File: doc/BRIEF.md
# Conditional Program Flow Sequencer

This block produces the program address for a small DSP-style core. Each cycle it takes one decoded flow operation and a 4-bit condition code. The operations are jump, call, return from subroutine, return from interrupt, idle, and counter load. The block then decides whether the flow change is taken and loads the program counter. A jump or call target comes from an immediate field or from an index-register value that an address generator outside the block supplies.

The block holds three pieces of state. A loop down-counter feeds the counter-expired condition. A four-entry return stack is shared by calls and interrupt entry. A low-power idle state holds the program counter until an interrupt request arrives. The interrupt request brings its own vector address. Priority and masking are decided upstream. Errors are reported as one-cycle pulses on the cycle after the event: a condition that is not allowed with the chosen operation, a push to a full stack, and a pop from an empty stack.

Top module: `flow_seq`

## Requirements
- R1: While reset is held, and on the first cycle after its release, `pc` is 0 and `idle_lp`, `illegal`, `stk_ovf` and `stk_unf` are all low.
- R2: When no flow change is taken (NOP = op 0, reserved op 7, counter load, idle, or any branch whose condition is false), the next `pc` is `pc+1`, wrapping modulo 2^14.
- R3: Condition codes are EQ=0 (`st_zero`), NE=1 (not `st_zero`), LT=2 (`st_neg`), GE=3 (not `st_neg`) and ALWAYS=15. Codes 8 to 14 always evaluate false.
- R4: A taken jump (op 1) loads `imm_addr` when `use_ind` is 0 and `ind_addr` when `use_ind` is 1.
- R5: A taken call (op 2) pushes `pc+1` and loads the target. A taken return from subroutine (op 3) pops the top entry into `pc`. A push and a pop never happen in the same cycle.
- R6: When `irq` is high and the block is not in the idle state, the operation presented is not executed. The current `pc` is pushed and `pc` loads `irq_vec`. A taken return from interrupt (op 4) pops that address back into `pc`.
- R7: Counter load (op 6) writes `cnt_load` into the loop counter. Condition CE=4 is true when the count is 1 at the test. NOT CE=5 is its inverse. Each evaluation of either code decrements a non-zero count by one.
- R8: FLAG_IN=6 and NOT FLAG_IN=7 test the level of `flag_in` on a jump or call with an immediate target.
- R9: A flag condition combined with `use_ind`=1, or used on a return, is not taken: `pc` advances by one, no stack change occurs, and `illegal` pulses high on the next cycle.
- R10: Idle (op 5) advances `pc` to the following address and raises `idle_lp`. While idle, `pc` holds and operations are ignored. An `irq` pushes the held `pc`, loads `irq_vec` and clears `idle_lp`.
- R11: An `irq` in the same cycle as an idle operation never enters low power. It pushes the address after the idle, so a later return resumes there.
- R12: The stack holds four entries. A push when full drops the entry, still loads the new `pc`, and pulses `stk_ovf` on the next cycle. A pop when empty leaves the stack unchanged, advances `pc` by one, and pulses `stk_unf` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Decoded flow operation (0 NOP, 1 jump, 2 call, 3 return sub, 4 return int, 5 idle, 6 counter load, 7 reserved) |
| cond | input | 4 | Condition code |
| use_ind | input | 1 | Select index-register target instead of immediate |
| imm_addr | input | 14 | Immediate target address |
| ind_addr | input | 14 | Index-register target address |
| cnt_load | input | 16 | Value for counter load |
| st_zero | input | 1 | Zero status flag |
| st_neg | input | 1 | Negative status flag |
| flag_in | input | 1 | External flag pin level |
| irq | input | 1 | Interrupt request (already prioritised) |
| irq_vec | input | 14 | Interrupt vector address |
| pc | output | 14 | Program counter |
| idle_lp | output | 1 | Low-power idle status |
| illegal | output | 1 | Illegal condition pulse |
| stk_ovf | output | 1 | Stack overflow pulse |
| stk_unf | output | 1 | Stack underflow pulse |

## Verification
The jump path is swept over all sixteen condition codes against every zero/negative combination and both flag levels. This separates codes that evaluate false from codes that track the status inputs. Counter loads followed by repeated CE and NOT CE jumps show when the expiry point occurs and that the count stops at zero. Call chains five deep, followed by five returns, test the overflow drop and the underflow on an empty stack. Interrupts arrive during ordinary operations, during a held idle state, and on the idle cycle itself. Each case pushes a different return address, and the following return exposes which one was pushed.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_JUMP  = 3'd1,
    OP_CALL  = 3'd2,
    OP_RETS  = 3'd3,
    OP_RETI  = 3'd4,
    OP_IDLE  = 3'd5,
    OP_LDCNT = 3'd6,
    OP_RSVD  = 3'd7
  } flow_op_e;

  localparam logic [3:0] CC_EQ     = 4'd0;
  localparam logic [3:0] CC_NE     = 4'd1;
  localparam logic [3:0] CC_LT     = 4'd2;
  localparam logic [3:0] CC_GE     = 4'd3;
  localparam logic [3:0] CC_CE     = 4'd4;
  localparam logic [3:0] CC_NCE    = 4'd5;
  localparam logic [3:0] CC_FLAG   = 4'd6;
  localparam logic [3:0] CC_NFLAG  = 4'd7;
  localparam logic [3:0] CC_ALWAYS = 4'd15;

  function automatic logic cc_uses_flag(input logic [3:0] c);
    return (c == CC_FLAG) || (c == CC_NFLAG);
  endfunction

  function automatic logic cc_uses_count(input logic [3:0] c);
    return (c == CC_CE) || (c == CC_NCE);
  endfunction

  function automatic logic op_is_branch(input flow_op_e o);
    return (o == OP_JUMP) || (o == OP_CALL) || (o == OP_RETS) || (o == OP_RETI);
  endfunction

  function automatic logic op_takes_target(input flow_op_e o);
    return (o == OP_JUMP) || (o == OP_CALL);
  endfunction

  // Truth of a condition code given status, pin level and counter state.
  function automatic logic cc_eval(input logic [3:0] c, input logic z, input logic n,
                                   input logic f, input logic cnt_hit);
    logic r;
    case (c)
      CC_EQ:     r = z;
      CC_NE:     r = !z;
      CC_LT:     r = n;
      CC_GE:     r = !n;
      CC_CE:     r = cnt_hit;
      CC_NCE:    r = !cnt_hit;
      CC_FLAG:   r = f;
      CC_NFLAG:  r = !f;
      CC_ALWAYS: r = 1'b1;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/flow_cond_unit.sv
module flow_cond_unit
  import flow_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       cc,
  input  logic             eval_en,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             st_zero,
  input  logic             st_neg,
  input  logic             flag_in,
  output logic             cc_true,
  output logic             cnt_step
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_hit;

  assign cnt_hit  = (cnt_q == CNT_ONE);
  assign cc_true  = cc_eval(cc, st_zero, st_neg, flag_in, cnt_hit);
  assign cnt_step = eval_en && cc_uses_count(cc) && (cnt_q != CNT_ZERO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
    end else if (ld_en) begin
      cnt_q <= ld_val;
    end else if (cnt_step) begin
      cnt_q <= cnt_q - CNT_ONE;
    end
  end

endmodule

// File: rtl/flow_ret_stack.sv
module flow_ret_stack #(
  parameter int AW    = 14,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_data,
  output logic          full,
  output logic          empty
);

  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] ONE_CNT  = PW'(1);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] depth_q;
  logic [PW-1:0] top_ptr;

  assign full     = (depth_q == FULL_CNT);
  assign empty    = (depth_q == '0);
  assign top_ptr  = depth_q - ONE_CNT;
  assign top_data = empty ? '0 : mem[top_ptr[IW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else if (push && !full) begin
      depth_q <= depth_q + ONE_CNT;
    end else if (pop && !empty) begin
      depth_q <= depth_q - ONE_CNT;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[depth_q[IW-1:0]] <= push_data;
    end
  end

endmodule

// File: rtl/flow_next_pc.sv
module flow_next_pc
  import flow_seq_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic [AW-1:0] pc_q,
  input  logic          idle_q,
  input  logic          irq,
  input  logic [AW-1:0] irq_vec,
  input  flow_op_e      op_e,
  input  logic          taken,
  input  logic [AW-1:0] target,
  input  logic [AW-1:0] stk_top,
  input  logic          stk_empty,
  output logic [AW-1:0] pc_d,
  output logic          idle_d,
  output logic [AW-1:0] push_addr
);

  function automatic logic [AW-1:0] seq_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic [AW-1:0] pc_inc;
  assign pc_inc = seq_next(pc_q);

  // Return address for interrupt entry: the next instruction not yet run.
  always_comb begin
    if (irq) begin
      if (!idle_q && op_e == OP_IDLE) push_addr = pc_inc;
      else                            push_addr = pc_q;
    end else begin
      push_addr = pc_inc;
    end
  end

  always_comb begin
    pc_d   = pc_inc;
    idle_d = 1'b0;
    if (irq) begin
      pc_d = irq_vec;
    end else if (idle_q) begin
      pc_d   = pc_q;
      idle_d = 1'b1;
    end else if (taken) begin
      case (op_e)
        OP_JUMP, OP_CALL: pc_d = target;
        OP_RETS, OP_RETI: pc_d = stk_empty ? pc_inc : stk_top;
        default:          pc_d = pc_inc;
      endcase
    end else begin
      idle_d = (op_e == OP_IDLE);
    end
  end

endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_seq_pkg::*;
#(
  parameter int AW    = 14,
  parameter int CNT_W = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic [3:0]       cond,
  input  logic             use_ind,
  input  logic [AW-1:0]    imm_addr,
  input  logic [AW-1:0]    ind_addr,
  input  logic [CNT_W-1:0] cnt_load,
  input  logic             st_zero,
  input  logic             st_neg,
  input  logic             flag_in,
  input  logic             irq,
  input  logic [AW-1:0]    irq_vec,
  output logic [AW-1:0]    pc,
  output logic             idle_lp,
  output logic             illegal,
  output logic             stk_ovf,
  output logic             stk_unf
);

  flow_op_e      op_e;
  logic [AW-1:0] pc_q, pc_d, target, stk_top, push_addr;
  logic          idle_q, idle_d;
  logic          run, is_branch, flag_bad, eval_en, cc_true, cnt_step;
  logic          taken, evt_push, evt_pop, stk_full, stk_empty;
  logic          ill_q, ovf_q, unf_q;

  assign op_e      = flow_op_e'(op);
  assign run       = !idle_q && !irq;
  assign is_branch = op_is_branch(op_e);
  assign flag_bad  = run && is_branch && cc_uses_flag(cond)
                     && !(op_takes_target(op_e) && !use_ind);
  assign eval_en   = run && is_branch && !flag_bad;
  assign taken     = eval_en && cc_true;
  assign target    = use_ind ? ind_addr : imm_addr;
  assign evt_push  = irq || (taken && op_e == OP_CALL);
  assign evt_pop   = taken && (op_e == OP_RETS || op_e == OP_RETI);

  flow_cond_unit #(.CNT_W(CNT_W)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .cc       (cond),
    .eval_en  (eval_en),
    .ld_en    (run && op_e == OP_LDCNT),
    .ld_val   (cnt_load),
    .st_zero  (st_zero),
    .st_neg   (st_neg),
    .flag_in  (flag_in),
    .cc_true  (cc_true),
    .cnt_step (cnt_step)
  );

  flow_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (evt_push),
    .pop       (evt_pop),
    .push_data (push_addr),
    .top_data  (stk_top),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  flow_next_pc #(.AW(AW)) u_next (
    .pc_q      (pc_q),
    .idle_q    (idle_q),
    .irq       (irq),
    .irq_vec   (irq_vec),
    .op_e      (op_e),
    .taken     (taken),
    .target    (target),
    .stk_top   (stk_top),
    .stk_empty (stk_empty),
    .pc_d      (pc_d),
    .idle_d    (idle_d),
    .push_addr (push_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      idle_q <= 1'b0;
      ill_q  <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      idle_q <= idle_d;
      ill_q  <= flag_bad;
      ovf_q  <= evt_push && stk_full;
      unf_q  <= evt_pop && stk_empty;
    end
  end

  assign pc      = pc_q;
  assign idle_lp = idle_q;
  assign illegal = ill_q;
  assign stk_ovf = ovf_q;
  assign stk_unf = unf_q;

endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pc,
  input logic          idle_lp,
  input logic          irq,
  input logic [AW-1:0] irq_vec,
  input logic          illegal,
  input logic          stk_ovf,
  input logic          stk_unf,
  input logic          evt_push,
  input logic          evt_pop,
  input logic          stk_full,
  input logic          stk_empty,
  input logic          flag_bad,
  input logic          cnt_step
);

  AST_IRQ_LOADS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> pc == $past(irq_vec)); // R6

  AST_IDLE_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    idle_lp && !irq |=> $stable(pc) && idle_lp); // R10

  AST_IRQ_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !idle_lp); // R11

  AST_NO_PUSH_WITH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_push && evt_pop)); // R5

  AST_OVF_ON_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    evt_push && stk_full |=> stk_ovf); // R12

  AST_UNF_ON_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pop && stk_empty |=> stk_unf); // R12

  AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    flag_bad |=> illegal && pc == AW'($past(pc) + 1'b1)); // R9

  AST_ILLEGAL_NO_STACK: assert property (@(posedge clk) disable iff (!rst_n)
    flag_bad |-> !evt_pop && !cnt_step); // R9

endmodule

bind flow_seq flow_seq_chk #(.AW(AW)) u_flow_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pc        (pc),
  .idle_lp   (idle_lp),
  .irq       (irq),
  .irq_vec   (irq_vec),
  .illegal   (illegal),
  .stk_ovf   (stk_ovf),
  .stk_unf   (stk_unf),
  .evt_push  (evt_push),
  .evt_pop   (evt_pop),
  .stk_full  (stk_full),
  .stk_empty (stk_empty),
  .flag_bad  (flag_bad),
  .cnt_step  (cnt_step)
);

// File: tb/test_flow_seq.sv
`timescale 1ns/1ps
module test_flow_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [3:0]  cond = 4'd0;
  logic        use_ind = 1'b0;
  logic [13:0] imm_addr = '0;
  logic [13:0] ind_addr = '0;
  logic [15:0] cnt_load = '0;
  logic        st_zero = 1'b0;
  logic        st_neg = 1'b0;
  logic        flag_in = 1'b0;
  logic        irq = 1'b0;
  logic [13:0] irq_vec = '0;
  logic [13:0] pc;
  logic        idle_lp, illegal, stk_ovf, stk_unf;

  int n_vec = 0;
  int n_bad = 0;

  // reference state
  int m_pc = 0;
  int m_cnt = 0;
  bit m_idle = 0;
  int m_stk[$];
  bit e_ill = 0, e_ovf = 0, e_unf = 0;

  flow_seq i_flow_seq (
    .clk(clk), .rst_n(rst_n), .op(op), .cond(cond), .use_ind(use_ind),
    .imm_addr(imm_addr), .ind_addr(ind_addr), .cnt_load(cnt_load),
    .st_zero(st_zero), .st_neg(st_neg), .flag_in(flag_in), .irq(irq),
    .irq_vec(irq_vec), .pc(pc), .idle_lp(idle_lp), .illegal(illegal),
    .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  always #10 clk = ~clk;

  task automatic m_push(input int a);
    if (m_stk.size() >= 4) e_ovf = 1;
    else m_stk.push_back(a);
  endtask

  task automatic model_step();
    int  tgt;
    bit  rn, br, ev, ct;
    tgt = use_ind ? int'(ind_addr) : int'(imm_addr);
    rn  = !m_idle && !irq;
    br  = (op >= 1 && op <= 4);
    e_ill = 0; e_ovf = 0; e_unf = 0;
    if (rn && br && (cond == 6 || cond == 7) && !((op == 1 || op == 2) && !use_ind))
      e_ill = 1;
    ev = rn && br && !e_ill;
    case (cond)
      0: ct = st_zero;
      1: ct = !st_zero;
      2: ct = st_neg;
      3: ct = !st_neg;
      4: ct = (m_cnt == 1);
      5: ct = (m_cnt != 1);
      6: ct = flag_in;
      7: ct = !flag_in;
      15: ct = 1;
      default: ct = 0;
    endcase
    if (ev && (cond == 4 || cond == 5) && m_cnt != 0) m_cnt = m_cnt - 1;
    if (rn && op == 6) m_cnt = cnt_load;
    if (irq) begin
      if (!m_idle && op == 5) m_push((m_pc + 1) % 16384);
      else m_push(m_pc);
      m_pc = irq_vec;
      m_idle = 0;
    end else if (m_idle) begin
      // held
    end else if (ev && ct) begin
      if (op == 1) m_pc = tgt;
      else if (op == 2) begin
        m_push((m_pc + 1) % 16384);
        m_pc = tgt;
      end else if (m_stk.size() == 0) begin
        e_unf = 1;
        m_pc = (m_pc + 1) % 16384;
      end else m_pc = m_stk.pop_back();
    end else begin
      m_pc = (m_pc + 1) % 16384;
      if (op == 5) m_idle = 1;
    end
  endtask

  task automatic check(input string tag);
    n_vec++;
    if (int'(pc) != m_pc || idle_lp != m_idle || illegal != e_ill ||
        stk_ovf != e_ovf || stk_unf != e_unf) begin
      n_bad++;
      $display("FAIL %s: pc/idle/ill/ovf/unf actual %0d/%0b/%0b/%0b/%0b expected %0d/%0b/%0b/%0b/%0b",
               tag, pc, idle_lp, illegal, stk_ovf, stk_unf, m_pc, m_idle, e_ill, e_ovf, e_unf);
    end
  endtask

  task automatic step(input string tag);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  task automatic issue(input int o, input int c, input bit ind, input int ia,
                       input int xa, input string tag);
    op = 3'(o); cond = 4'(c); use_ind = ind;
    imm_addr = 14'(ia); ind_addr = 14'(xa); irq = 0;
    step(tag);
  endtask

  task automatic interrupt(input int vec, input int o, input string tag);
    op = 3'(o); cond = 4'd15; use_ind = 0; irq = 1; irq_vec = 14'(vec);
    step(tag);
    irq = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset held");
    rst_n = 1'b1;
    step("R1 first cycle");
    // R2 sequential advance
    for (int i = 0; i < 3; i++) issue(0, 0, 0, 0, 0, "R2 nop");
    issue(7, 15, 0, 99, 99, "R2 reserved op");
    // R4 target select
    issue(1, 15, 0, 100, 300, "R4 imm jump");
    issue(1, 15, 1, 500, 16383, "R4 ind jump");
    issue(0, 0, 0, 0, 0, "R2 wrap");
    // R3 and R8 sweep
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 8; s++) begin
        st_zero = s[0]; st_neg = s[1]; flag_in = s[2];
        issue(1, c, 0, 1000 + c * 8 + s, 0, (c == 6 || c == 7) ? "R8 flag" : "R3 cond");
      end
    // R5 call/return
    issue(2, 15, 0, 2000, 0, "R5 call");
    issue(0, 0, 0, 0, 0, "R2 nop");
    issue(3, 15, 0, 0, 0, "R5 return");
    // R12 overflow and underflow
    for (int i = 0; i < 5; i++) issue(2, 15, 0, 3000 + i * 16, 0, "R12 nested call");
    for (int i = 0; i < 5; i++) issue(3, 15, 0, 0, 0, "R12 return chain");
    // R7 counter
    cnt_load = 16'd3;
    issue(6, 0, 0, 0, 0, "R7 load");
    for (int i = 0; i < 5; i++) issue(1, 4, 0, 4000 + i, 0, "R7 CE");
    cnt_load = 16'd2;
    issue(6, 0, 0, 0, 0, "R7 load");
    for (int i = 0; i < 4; i++) issue(1, 5, 0, 4100 + i, 0, "R7 NOT CE");
    // R9 illegal
    flag_in = 1;
    issue(1, 6, 1, 4200, 4300, "R9 flag indirect");
    issue(0, 0, 0, 0, 0, "R9 pulse clears");
    issue(2, 7, 0, 4400, 0, "R8 call nflag");
    issue(4, 6, 0, 0, 0, "R9 flag on return");
    issue(3, 15, 0, 0, 0, "R5 return");
    // R6 interrupt entry and return
    issue(1, 15, 0, 5000, 0, "R4 jump");
    interrupt(6000, 1, "R6 irq preempts");
    issue(0, 0, 0, 0, 0, "R2 nop");
    issue(4, 15, 0, 0, 0, "R6 return int");
    // R10 idle
    issue(5, 0, 0, 0, 0, "R10 idle enter");
    for (int i = 0; i < 4; i++) issue(1, 15, 0, 7000, 0, "R10 ops ignored");
    interrupt(7100, 0, "R10 wake");
    issue(4, 15, 0, 0, 0, "R10 resume");
    // R11 irq on idle cycle
    issue(5, 0, 0, 0, 0, "R10 idle");
    interrupt(7200, 0, "R10 wake");
    issue(4, 15, 0, 0, 0, "R10 resume");
    op = 3'd5; cond = 0; irq = 1; irq_vec = 14'd7300;
    step("R11 irq with idle");
    irq = 0;
    issue(4, 15, 0, 0, 0, "R11 resume after idle");
    issue(0, 0, 0, 0, 0, "R11 not idle");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule